// File: doc/BRIEF.md
# Timing-Speculative Pipeline Register with One-Cycle Recovery

This block is one pipeline register bank for a pipeline that runs at a supply voltage below its worst-case margin. Each data bit is captured twice. A main register takes the value on the normal clock edge. A shadow register holds the value that the same bit settled to later, after a delayed clock. In RTL the delayed capture is modelled by the `lateData` input, which the shadow register takes at the same edge as the main register. When the two copies disagree on a valid entry, the stage has captured a wrong value.

On a detected error the stage marks its output as a bubble for that cycle. At the next edge it copies the shadow value into the main register. It also ignores the input offered at that edge. The registered error and flush outputs then pulse for one cycle, so the earlier stages know they must replay the instruction that was dropped. The stage treats that cycle as the correction cycle. Normal operation resumes at the edge after it.

Because the output is marked valid only after the comparison has passed, a downstream writeback that is qualified by `outValid` never commits a wrong capture. A saturating counter of detected errors is available for voltage-tuning policy. Without errors the block is a plain register with one cycle of latency.

Top module: `tsrStage`

## Requirements
- R1: While reset is low, and in the first cycle after reset, `outValid`, `errFlag` and `flushReq` are 0 and `errCount` is 0.
- R2: Without a mismatch, `outData` and `outValid` equal the `inData` and `inValid` applied one clock edge earlier.
- R3: When a valid captured entry differs from its shadow sample, `outValid` is 0 in that cycle. This cycle is the bubble.
- R4: In the cycle after the bubble, `outData` holds the shadow value and `outValid` is 1.
- R5: `errFlag` and `flushReq` are both 1 for exactly the cycle after the bubble. The input applied at the edge that opens that cycle never reaches `outData`.
- R6: A mismatch on an entry captured with `inValid` = 0 is ignored. It raises no error and no flush, leaves `errCount` unchanged, and `outValid` stays 0.
- R7: A difference in any single bit, including bit 0 and bit DATA_W-1, is detected as a stage error.
- R8: `errCount` rises by one for each detected error and saturates at all ones.
- R9: After the correction cycle, the next input is captured normally and appears one edge later with no further bubble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inData | input | DATA_W | Data captured on the normal edge |
| inValid | input | 1 | Entry qualifier for `inData` |
| lateData | input | DATA_W | Late (delayed-clock) sample of the same data |
| outData | output | DATA_W | Registered stage data |
| outValid | output | 1 | 1 for valid data, 0 for a bubble |
| errFlag | output | 1 | Stabilised stage error, one-cycle pulse |
| flushReq | output | 1 | Replay request to earlier stages |
| errCount | output | ERR_CNT_W | Saturating count of detected errors (default width 16) |

## Verification
The bench builds the block with DATA_W = 8 and ERR_CNT_W = 4. The narrow data path keeps the top and bottom bit positions easy to target for single-bit mismatches. The 4-bit counter reaches saturation after fifteen errors, which a 16-bit default width would put far out of reach. The directed scenarios cover clean streaming, the bubble and correction sequence, ignored mismatches on empty entries, errors on consecutive entries, and overflow of the counter.

// File: rtl/tsrPkg.sv
package tsrPkg;
  typedef struct packed {
    logic capture;
    logic restore;
  } tsrStrobes_t;
endpackage

// File: rtl/tsrDatapath.sv
module tsrDatapath
  import tsrPkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] inData,
  input  logic [DATA_W-1:0] lateData,
  input  tsrStrobes_t       strobes,
  output logic [DATA_W-1:0] outData,
  output logic              anyMismatch
);
  logic [DATA_W-1:0] mainQ;
  logic [DATA_W-1:0] shadowQ;
  logic [DATA_W-1:0] bitErr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mainQ   <= '0;
      shadowQ <= '0;
    end else if (strobes.restore) begin
      mainQ   <= shadowQ;
    end else if (strobes.capture) begin
      mainQ   <= inData;
      shadowQ <= lateData;
    end
  end

  for (genvar g = 0; g < DATA_W; g++) begin : gBitCmp
    assign bitErr[g] = mainQ[g] ^ shadowQ[g];
  end

  assign anyMismatch = |bitErr;
  assign outData     = mainQ;

  // After a restore the corrected main copy agrees with its shadow.
  assert_restore_clean_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.restore |=> !anyMismatch);
endmodule

// File: rtl/tsrControl.sv
module tsrControl
  import tsrPkg::*;
#(
  parameter int ERR_CNT_W = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  input  logic                 anyMismatch,
  output tsrStrobes_t          strobes,
  output logic                 outValid,
  output logic                 errFlag,
  output logic                 flushReq,
  output logic [ERR_CNT_W-1:0] errCount
);
  localparam logic [ERR_CNT_W-1:0] CNT_MAX = '1;

  logic                 stageValid;
  logic                 errStab;
  logic [ERR_CNT_W-1:0] cnt;
  logic                 detect;

  assign detect          = stageValid & anyMismatch;
  assign strobes.restore = detect;
  assign strobes.capture = ~detect;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stageValid <= 1'b0;
      errStab    <= 1'b0;
      cnt        <= '0;
    end else begin
      stageValid <= detect ? 1'b1 : inValid;
      errStab    <= detect;
      if (detect && cnt != CNT_MAX) cnt <= cnt + 1'b1;
    end
  end

  assign outValid = stageValid & ~detect;
  assign errFlag  = errStab;
  assign flushReq = errStab;
  assign errCount = cnt;

  assert_pulse_once_R5: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> !errFlag);
  assert_corrected_valid_R4: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> outValid);
  assert_empty_ignored_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!inValid && !detect) |=> (!outValid && !detect));
  assert_count_monotonic_R8: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> errCount >= $past(errCount));
  assert_count_saturate_R8: assert property (@(posedge clk) disable iff (!rstN)
    (errCount == CNT_MAX) |=> (errCount == CNT_MAX));
endmodule

// File: rtl/tsrStage.sv
module tsrStage
  import tsrPkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ERR_CNT_W = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [DATA_W-1:0]    inData,
  input  logic                 inValid,
  input  logic [DATA_W-1:0]    lateData,
  output logic [DATA_W-1:0]    outData,
  output logic                 outValid,
  output logic                 errFlag,
  output logic                 flushReq,
  output logic [ERR_CNT_W-1:0] errCount
);
  tsrStrobes_t strobes;
  logic        anyMismatch;

  tsrDatapath #(.DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .inData(inData), .lateData(lateData),
    .strobes(strobes), .outData(outData), .anyMismatch(anyMismatch)
  );

  tsrControl #(.ERR_CNT_W(ERR_CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .anyMismatch(anyMismatch),
    .strobes(strobes), .outValid(outValid), .errFlag(errFlag),
    .flushReq(flushReq), .errCount(errCount)
  );
endmodule

// File: tb/sim_tsrStage.sv
`timescale 1ns/1ps
module sim_tsrStage;
  localparam int DW = 8;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [DW-1:0] inData = '0;
  logic          inValid = 1'b0;
  logic [DW-1:0] lateData = '0;
  logic [DW-1:0] outData;
  logic          outValid, errFlag, flushReq;
  logic [CW-1:0] errCount;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int expCnt = 0;

  always #4 clk = ~clk;

  tsrStage #(.DATA_W(DW), .ERR_CNT_W(CW)) u0 (
    .clk(clk), .rstN(rstN), .inData(inData), .inValid(inValid),
    .lateData(lateData), .outData(outData), .outValid(outValid),
    .errFlag(errFlag), .flushReq(flushReq), .errCount(errCount)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Apply inputs away from the edge, pass one rising edge, sample shortly after.
  task automatic step(input logic [DW-1:0] d, input logic [DW-1:0] l, input logic v);
    @(negedge clk);
    inData = d; lateData = l; inValid = v;
    @(posedge clk);
    #1;
  endtask

  task automatic tReset();
    chk("R1 outValid in reset", outValid, 0);
    chk("R1 errFlag in reset", errFlag, 0);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #1;
    chk("R1 outValid after reset", outValid, 0);
    chk("R1 flushReq after reset", flushReq, 0);
    chk("R1 errCount after reset", errCount, 0);
  endtask

  task automatic tClean();
    step(8'h3c, 8'h3c, 1);
    chk("R2 data", outData, 8'h3c); chk("R2 valid", outValid, 1);
    chk("R2 no err", errFlag, 0);
    step(8'hc5, 8'hc5, 1);
    chk("R2 data seq", outData, 8'hc5);
    step(8'h11, 8'h11, 0);
    chk("R2 invalid passes", outValid, 0);
  endtask

  // Error on one entry: bubble, correction, replay request, resume.
  task automatic tErr(input logic [DW-1:0] early, input logic [DW-1:0] late, input string tag);
    step(early, late, 1);
    chk({tag, " R3 bubble"}, outValid, 0);
    chk({tag, " R3 no flag yet"}, errFlag, 0);
    step(8'hee, 8'hee, 1);
    expCnt = (expCnt < 15) ? expCnt + 1 : 15;
    chk({tag, " R4 corrected data"}, outData, late);
    chk({tag, " R4 valid"}, outValid, 1);
    chk({tag, " R5 errFlag"}, errFlag, 1);
    chk({tag, " R5 flushReq"}, flushReq, 1);
    chk({tag, " R8 count"}, errCount, expCnt);
    step(8'h5a, 8'h5a, 1);
    chk({tag, " R5 flag drops"}, errFlag, 0);
    chk({tag, " R5 dropped input absent"}, (outData == 8'hee) ? 1 : 0, 0);
    chk({tag, " R9 resume data"}, outData, 8'h5a);
    chk({tag, " R9 resume valid"}, outValid, 1);
  endtask

  task automatic tIgnored();
    step(8'h0f, 8'hf0, 0);
    chk("R6 no valid", outValid, 0);
    step(8'h22, 8'h22, 1);
    chk("R6 no err", errFlag, 0);
    chk("R6 no flush", flushReq, 0);
    chk("R6 count kept", errCount, expCnt);
    chk("R6 next data", outData, 8'h22);
  endtask

  task automatic tBackToBack();
    step(8'h40, 8'h41, 1);
    step(8'h70, 8'h78, 1);   // dropped at the correction edge
    chk("R4 b2b corrected", outData, 8'h41);
    step(8'h70, 8'h78, 1);   // replayed, mismatches again
    chk("R9 b2b second bubble", outValid, 0);
    chk("R9 b2b flag low", errFlag, 0);
    step(8'h01, 8'h01, 1);
    chk("R4 b2b second corrected", outData, 8'h78);
    chk("R5 b2b second flag", errFlag, 1);
    expCnt = (expCnt + 2 < 15) ? expCnt + 2 : 15;
    chk("R8 b2b count", errCount, expCnt);
    step(8'h02, 8'h02, 1);
  endtask

  task automatic tSaturate();
    for (int i = 0; i < 16; i++) begin
      step(8'h00, 8'h04, 1);
      step(8'h00, 8'h00, 0);
    end
    expCnt = 15;
    chk("R8 saturated", errCount, 15);
    step(8'h00, 8'h80, 1);
    step(8'h00, 8'h00, 0);
    chk("R8 stays saturated", errCount, 15);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    tReset();
    tClean();
    tErr(8'h80, 8'h00, "R7 msb");
    tErr(8'h00, 8'h01, "R7 lsb");
    tErr(8'ha5, 8'h5a, "multi");
    tIgnored();
    tBackToBack();
    tSaturate();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule